// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block carries out the entry into an exception for an 8-bit processor whose stack grows downward inside one fixed memory page. When the core reports an instruction boundary, the sequencer looks at the pending requests and decides whether to enter. The requests are a non-maskable request, a set of level interrupt sources and a one-shot maskable request. If it enters, it saves the return address and the status on the stack, then fetches a two-byte vector. In the last cycle it hands the core a new program counter, status and stack pointer. Reset uses the same vector-fetch path but does not push anything.

The core keeps ownership of its registers. It presents the current PC, status and stack pointer, together with the interrupt-disable bit it sampled before the current instruction. It accepts the values the sequencer loads. While `busy` is high the core must not fetch. Stack writes and vector reads go out on a single byte-wide memory port. That port has a synchronous read: the data returns in the cycle after the read strobe.

Top module: `intseq_top`

## Requirements
- R1: From the cycle reset is released, the block reads address 0xFFFC and then 0xFFFD. It then pulses `pc_load` with PC = {byte at 0xFFFD, byte at 0xFFFC} and `p_load` with status 0x04. `jam_clr` pulses in the same cycle. There is no stack write and no `sp_load`.
- R2: An entry writes exactly three bytes, in this order: PC[15:8], PC[7:0], status. They go to 0x0100+S, 0x0100+((S-1) mod 256) and 0x0100+((S-2) mod 256), where S is `sp_in` at acceptance. The loaded `sp_out` is (S-3) mod 256.
- R3: The stacked status byte equals the accepted status with bit 4 forced to 0 and bit 5 forced to 1.
- R4: A non-maskable entry reads 0xFFFA (low byte) and then 0xFFFB (high byte). The loaded status is the accepted status with bit 4 cleared and all other bits unchanged.
- R5: A maskable entry reads 0xFFFE (low byte) and then 0xFFFF (high byte). The loaded status is the accepted status with bit 4 cleared and bit 2 set.
- R6: A maskable entry is taken only when `i_prev` is 0 and `jammed` is 0. A non-maskable request is refused only when `jammed` is 1.
- R7: When a non-maskable request and a maskable request are both seen at one boundary, the non-maskable entry is the one taken.
- R8: Every evaluated boundary discards the pending non-maskable and one-shot requests, whether or not an entry results. Level sources in `irq_src` are not latched, so a bit that stays set requests again at the next boundary.
- R9: A request is evaluated only in a cycle with `insn_boundary` = 1 and `busy` = 0. `busy` rises in the next cycle and stays high for exactly 7 cycles, and `pc_load` pulses in the seventh. A non-maskable request that arrives while busy, or away from a boundary, is held until the next evaluation.
- R10: `mem_wr` and `mem_rd` are never high together. Read data is taken from `mem_rdata` one cycle after its `mem_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also starts reset entry |
| irq_src | input | NSRC | Level maskable request sources, one bit each |
| irq_pulse | input | 1 | One-shot maskable request strobe |
| nmi_req | input | 1 | Non-maskable request strobe |
| jammed | input | 1 | Core is halted |
| insn_boundary | input | 1 | Core is between instructions |
| i_prev | input | 1 | Interrupt-disable bit sampled before the current instruction |
| cur_pc | input | 2*DW | Current program counter |
| cur_p | input | 8 | Current status |
| sp_in | input | DW | Current stack pointer |
| mem_rdata | input | DW | Read data, valid the cycle after mem_rd |
| mem_addr | output | 2*DW | Memory address |
| mem_wdata | output | DW | Write data |
| mem_wr | output | 1 | Write strobe |
| mem_rd | output | 1 | Read strobe |
| busy | output | 1 | Entry in progress; fetch blocked |
| pc_out | output | 2*DW | New program counter |
| pc_load | output | 1 | Load pc_out into the core |
| p_out | output | 8 | New status |
| p_load | output | 1 | Load p_out into the core |
| sp_out | output | DW | New stack pointer |
| sp_load | output | 1 | Load sp_out into the core |
| jam_clr | output | 1 | Clear the core's halt flag |

## Verification
Two functions can fall in the same cycle. One is arbitration between a non-maskable request and a maskable request at the same boundary. The other is the clearing of the pending non-maskable bit at evaluation colliding with a fresh non-maskable strobe during an entry that is already under way. The bench provokes the first by raising both requests before a single boundary. It judges the result by the vector address read, and then confirms that the still-set level source gives a maskable entry at the following boundary. It provokes the second by strobing `nmi_req` two cycles into a maskable entry, and expects a complete non-maskable entry at the next boundary.

// File: rtl/intseq_pkg.sv
package intseq_pkg;

  // Kind of entry being carried out
  typedef enum logic [1:0] {
    K_RESET = 2'd0,
    K_NMI   = 2'd1,
    K_IRQ   = 2'd2
  } kind_t;

  // Sequencer states; every state except ST_IDLE is a busy cycle
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PUSH_H = 3'd1,
    ST_PUSH_L = 3'd2,
    ST_PUSH_P = 3'd3,
    ST_VEC_L  = 3'd4,
    ST_VEC_H  = 3'd5,
    ST_VEC_W  = 3'd6,
    ST_LOAD   = 3'd7
  } state_t;

  localparam int SW = 8;

  localparam logic [SW-1:0] FLAG_I = 8'h04;
  localparam logic [SW-1:0] FLAG_B = 8'h10;
  localparam logic [SW-1:0] FLAG_U = 8'h20;

  localparam logic [SW-1:0] RESET_STATUS = FLAG_I;

endpackage

// File: rtl/intseq_arbiter.sv
module intseq_arbiter
  import intseq_pkg::*;
#(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            eval,
  input  logic [NSRC-1:0] irq_src,
  input  logic            irq_pulse,
  input  logic            nmi_req,
  input  logic            jammed,
  input  logic            i_prev,
  output logic            take_nmi,
  output logic            take_irq
);

  logic nmi_pend_q;
  logic os_pend_q;
  logic nmi_seen;
  logic os_seen;
  logic irq_any;

  assign nmi_seen = nmi_pend_q | nmi_req;
  assign os_seen  = os_pend_q | irq_pulse;
  assign irq_any  = (|irq_src) | os_seen;

  // Non-maskable first; a seen non-maskable request blocks the maskable
  // path at this boundary even when it is itself refused.
  assign take_nmi = eval & nmi_seen & ~jammed;
  assign take_irq = eval & ~nmi_seen & irq_any & ~i_prev & ~jammed;

  // Strobed requests are consumed at every evaluation
  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_pend_q <= 1'b0;
      os_pend_q  <= 1'b0;
    end else if (eval) begin
      nmi_pend_q <= 1'b0;
      os_pend_q  <= 1'b0;
    end else begin
      nmi_pend_q <= nmi_seen;
      os_pend_q  <= os_seen;
    end
  end

endmodule

// File: rtl/intseq_fsm.sv
module intseq_fsm
  import intseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   accept,
  input  kind_t  kind_in,
  output state_t state,
  output kind_t  kind,
  output logic   busy
);

  state_t state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE:   if (accept) state_d = ST_PUSH_H;
      ST_PUSH_H: state_d = ST_PUSH_L;
      ST_PUSH_L: state_d = ST_PUSH_P;
      ST_PUSH_P: state_d = ST_VEC_L;
      ST_VEC_L:  state_d = ST_VEC_H;
      ST_VEC_H:  state_d = ST_VEC_W;
      ST_VEC_W:  state_d = ST_LOAD;
      ST_LOAD:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // Reset parks the machine on the first vector read with kind RESET
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_VEC_L;
      kind  <= K_RESET;
    end else begin
      state <= state_d;
      if (state == ST_IDLE && accept) kind <= kind_in;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/intseq_dp.sv
module intseq_dp
  import intseq_pkg::*;
#(
  parameter int             DW         = 8,
  parameter logic [DW-1:0]  STACK_PAGE = 8'h01,
  parameter logic [2*DW-1:0] VEC_NMI   = 16'hFFFA,
  parameter logic [2*DW-1:0] VEC_RST   = 16'hFFFC,
  parameter logic [2*DW-1:0] VEC_IRQ   = 16'hFFFE
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            accept,
  input  state_t          state,
  input  kind_t           kind,
  input  logic [2*DW-1:0] cur_pc,
  input  logic [SW-1:0]   cur_p,
  input  logic [DW-1:0]   sp_in,
  input  logic [DW-1:0]   mem_rdata,
  output logic [2*DW-1:0] mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_wr,
  output logic            mem_rd,
  output logic [2*DW-1:0] pc_out,
  output logic            pc_load,
  output logic [SW-1:0]   p_out,
  output logic            p_load,
  output logic [DW-1:0]   sp_out,
  output logic            sp_load,
  output logic            jam_clr
);

  localparam int AW = 2 * DW;

  logic [AW-1:0] pc_q;
  logic [SW-1:0] p_q;
  logic [DW-1:0] sp_q;
  logic [DW-1:0] lo_q;
  logic [DW-1:0] hi_q;
  logic [AW-1:0] vec_base;
  logic [SW-1:0] stacked_p;
  logic          pushing;

  assign pushing   = (state == ST_PUSH_H) || (state == ST_PUSH_L) ||
                     (state == ST_PUSH_P);
  assign stacked_p = (p_q & ~FLAG_B) | FLAG_U;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
      p_q  <= '0;
      sp_q <= '0;
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (accept) begin
        pc_q <= cur_pc;
        p_q  <= cur_p;
        sp_q <= sp_in;
      end
      if (pushing)            sp_q <= sp_q - 1'b1;
      if (state == ST_VEC_H)  lo_q <= mem_rdata;
      if (state == ST_VEC_W)  hi_q <= mem_rdata;
    end
  end

  always_comb begin
    unique case (kind)
      K_NMI:   vec_base = VEC_NMI;
      K_IRQ:   vec_base = VEC_IRQ;
      default: vec_base = VEC_RST;
    endcase
  end

  // Port outputs are multiplexed from the state and the latched data only
  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    mem_wr    = 1'b0;
    mem_rd    = 1'b0;
    pc_load   = 1'b0;
    p_load    = 1'b0;
    sp_load   = 1'b0;
    jam_clr   = 1'b0;
    p_out     = '0;
    unique case (state)
      ST_PUSH_H: begin
        mem_wr    = 1'b1;
        mem_addr  = {STACK_PAGE, sp_q};
        mem_wdata = pc_q[AW-1:DW];
      end
      ST_PUSH_L: begin
        mem_wr    = 1'b1;
        mem_addr  = {STACK_PAGE, sp_q};
        mem_wdata = pc_q[DW-1:0];
      end
      ST_PUSH_P: begin
        mem_wr    = 1'b1;
        mem_addr  = {STACK_PAGE, sp_q};
        mem_wdata = DW'(stacked_p);
      end
      ST_VEC_L: begin
        mem_rd   = 1'b1;
        mem_addr = vec_base;
      end
      ST_VEC_H: begin
        mem_rd   = 1'b1;
        mem_addr = vec_base + AW'(1);
      end
      ST_LOAD: begin
        pc_load = 1'b1;
        p_load  = 1'b1;
        unique case (kind)
          K_NMI: begin
            p_out   = p_q & ~FLAG_B;
            sp_load = 1'b1;
          end
          K_IRQ: begin
            p_out   = (p_q & ~FLAG_B) | FLAG_I;
            sp_load = 1'b1;
          end
          default: begin
            p_out   = RESET_STATUS;
            jam_clr = 1'b1;
          end
        endcase
      end
      default: ;
    endcase
  end

  assign pc_out = {hi_q, lo_q};
  assign sp_out = sp_q;

endmodule

// File: rtl/intseq_top.sv
module intseq_top
  import intseq_pkg::*;
#(
  parameter int              DW         = 8,
  parameter int              NSRC       = 4,
  parameter logic [DW-1:0]   STACK_PAGE = 8'h01,
  parameter logic [2*DW-1:0] VEC_NMI    = 16'hFFFA,
  parameter logic [2*DW-1:0] VEC_RST    = 16'hFFFC,
  parameter logic [2*DW-1:0] VEC_IRQ    = 16'hFFFE
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] irq_src,
  input  logic            irq_pulse,
  input  logic            nmi_req,
  input  logic            jammed,
  input  logic            insn_boundary,
  input  logic            i_prev,
  input  logic [2*DW-1:0] cur_pc,
  input  logic [7:0]      cur_p,
  input  logic [DW-1:0]   sp_in,
  input  logic [DW-1:0]   mem_rdata,
  output logic [2*DW-1:0] mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_wr,
  output logic            mem_rd,
  output logic            busy,
  output logic [2*DW-1:0] pc_out,
  output logic            pc_load,
  output logic [7:0]      p_out,
  output logic            p_load,
  output logic [DW-1:0]   sp_out,
  output logic            sp_load,
  output logic            jam_clr
);

  logic   eval;
  logic   take_nmi;
  logic   take_irq;
  logic   accept;
  kind_t  kind_in;
  kind_t  kind;
  state_t state;

  assign eval    = insn_boundary & ~busy;
  assign accept  = take_nmi | take_irq;
  assign kind_in = take_nmi ? K_NMI : K_IRQ;

  intseq_arbiter #(.NSRC(NSRC)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .eval      (eval),
    .irq_src   (irq_src),
    .irq_pulse (irq_pulse),
    .nmi_req   (nmi_req),
    .jammed    (jammed),
    .i_prev    (i_prev),
    .take_nmi  (take_nmi),
    .take_irq  (take_irq)
  );

  intseq_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .accept  (accept),
    .kind_in (kind_in),
    .state   (state),
    .kind    (kind),
    .busy    (busy)
  );

  intseq_dp #(
    .DW         (DW),
    .STACK_PAGE (STACK_PAGE),
    .VEC_NMI    (VEC_NMI),
    .VEC_RST    (VEC_RST),
    .VEC_IRQ    (VEC_IRQ)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .state     (state),
    .kind      (kind),
    .cur_pc    (cur_pc),
    .cur_p     (cur_p),
    .sp_in     (sp_in),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_wr    (mem_wr),
    .mem_rd    (mem_rd),
    .pc_out    (pc_out),
    .pc_load   (pc_load),
    .p_out     (p_out),
    .p_load    (p_load),
    .sp_out    (sp_out),
    .sp_load   (sp_load),
    .jam_clr   (jam_clr)
  );

endmodule

// File: rtl/intseq_checker.sv
module intseq_checker #(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            busy,
  input logic            mem_wr,
  input logic            mem_rd,
  input logic [2*DW-1:0] mem_addr,
  input logic [DW-1:0]   mem_wdata,
  input logic            pc_load,
  input logic            p_load,
  input logic            sp_load,
  input logic            jam_clr,
  input logic [7:0]      p_out
);

  logic [3:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_cnt <= '0;
    else              busy_cnt <= busy_cnt + 4'd1;
  end

  // R2: every write lands in the stack page
  p_wr_in_stack_r2: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> mem_addr[2*DW-1:DW] == DW'(1));

  // R2: consecutive pushes move one step downward
  p_push_desc_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && $past(mem_wr)) |->
      mem_addr[DW-1:0] == DW'($past(mem_addr[DW-1:0]) - DW'(1)));

  // R3: the third push carries U set and B clear
  p_stacked_flags_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && $past(mem_wr) && $past(mem_wr, 2)) |->
      (mem_wdata[5] && !mem_wdata[4]));

  // R1: reset load gives I-only status and no stack pointer load
  p_reset_load_r1: assert property (@(posedge clk) disable iff (rst)
    jam_clr |-> (pc_load && p_out == 8'h04 && !sp_load));

  // R4: interrupt loads clear B
  p_load_b_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (p_load && sp_load) |-> !p_out[4]);

  // R9: an interrupt entry loads in its seventh busy cycle
  p_busy_len_r9: assert property (@(posedge clk) disable iff (rst)
    (pc_load && sp_load) |-> busy_cnt == 4'd6);

  // R9: busy ends right after the load
  p_load_ends_r9: assert property (@(posedge clk) disable iff (rst)
    pc_load |=> !busy);

  // R10: one memory strobe at a time
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_wr, mem_rd, pc_load}));

endmodule

bind intseq_top intseq_checker #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .mem_wr    (mem_wr),
  .mem_rd    (mem_rd),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .pc_load   (pc_load),
  .p_load    (p_load),
  .sp_load   (sp_load),
  .jam_clr   (jam_clr),
  .p_out     (p_out)
);

// File: tb/tb_intseq_top.sv
`timescale 1ns/100ps
module tb_intseq_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  irq_src = '0;
  logic        irq_pulse = 1'b0;
  logic        nmi_req = 1'b0;
  logic        jammed = 1'b0;
  logic        insn_boundary = 1'b0;
  logic        i_prev = 1'b0;
  logic [15:0] cur_pc = '0;
  logic [7:0]  cur_p = '0;
  logic [7:0]  sp_in = '0;
  logic [7:0]  mem_rdata = '0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_wr, mem_rd, busy, pc_load, p_load, sp_load, jam_clr;
  logic [15:0] pc_out;
  logic [7:0]  p_out, sp_out;

  always #2.5 clk = ~clk;

  intseq_top dut (
    .clk(clk), .rst(rst), .irq_src(irq_src), .irq_pulse(irq_pulse),
    .nmi_req(nmi_req), .jammed(jammed), .insn_boundary(insn_boundary),
    .i_prev(i_prev), .cur_pc(cur_pc), .cur_p(cur_p), .sp_in(sp_in),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wr(mem_wr), .mem_rd(mem_rd), .busy(busy), .pc_out(pc_out),
    .pc_load(pc_load), .p_out(p_out), .p_load(p_load), .sp_out(sp_out),
    .sp_load(sp_load), .jam_clr(jam_clr)
  );

  int n_tests = 0;
  int n_fail  = 0;

  function automatic logic [7:0] vbyte(input logic [15:0] a);
    logic [7:0] t;
    t = a[7:0] * 8'd3;
    t = t + 8'h11;
    return t ^ a[15:8];
  endfunction

  // Synchronous-read memory model
  always @(posedge clk) if (mem_rd) mem_rdata <= vbyte(mem_addr);

  // Observation log, sampled on the falling edge
  logic [15:0] wa [8];
  logic [7:0]  wd [8];
  logic [15:0] ra [8];
  int wn, rn, busy_n, load_n;
  logic [15:0] l_pc;
  logic [7:0]  l_p, l_sp;
  logic        l_spl, l_jc;

  always @(negedge clk) begin
    if (busy) busy_n++;
    if (mem_wr) begin
      if (wn < 8) begin wa[wn] = mem_addr; wd[wn] = mem_wdata; end
      wn++;
    end
    if (mem_rd) begin
      if (rn < 8) ra[rn] = mem_addr;
      else begin
        for (int k = 0; k < 7; k++) ra[k] = ra[k+1];
        ra[7] = mem_addr;
      end
      rn++;
    end
    if (pc_load) begin
      load_n++;
      l_pc = pc_out; l_p = p_out; l_sp = sp_out;
      l_spl = sp_load; l_jc = jam_clr;
    end
  end

  task automatic clear_log();
    @(posedge clk);
    #1;
    wn = 0; rn = 0; busy_n = 0; load_n = 0;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_boundary();
    @(negedge clk) insn_boundary = 1'b1;
    @(negedge clk) insn_boundary = 1'b0;
  endtask

  task automatic pulse_nmi();
    @(negedge clk) nmi_req = 1'b1;
    @(negedge clk) nmi_req = 1'b0;
  endtask

  task automatic pulse_os();
    @(negedge clk) irq_pulse = 1'b1;
    @(negedge clk) irq_pulse = 1'b0;
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic setup(input logic [15:0] pc, input logic [7:0] p,
                       input logic [7:0] sp);
    @(negedge clk);
    cur_pc = pc; cur_p = p; sp_in = sp;
  endtask

  // is_nmi: 1 non-maskable, 0 maskable
  task automatic check_entry(input bit is_nmi, input string req);
    logic [15:0] base;
    logic [7:0]  ep;
    logic [7:0]  s1, s2, s3;
    base = is_nmi ? 16'hFFFA : 16'hFFFE;
    ep   = is_nmi ? (cur_p & 8'hEF) : ((cur_p & 8'hEF) | 8'h04);
    s1 = sp_in - 8'd1; s2 = sp_in - 8'd2; s3 = sp_in - 8'd3;
    chk(load_n == 1, req, "load count", load_n, 1);
    chk(busy_n == 7, "R9", "busy cycles", busy_n, 7);
    chk(wn == 3, "R2", "write count", wn, 3);
    chk(wa[0] == {8'h01, sp_in} && wa[1] == {8'h01, s1} &&
        wa[2] == {8'h01, s2}, "R2", "push addresses",
        {wa[0], wa[1], wa[2]}, {8'h01, sp_in, 8'h01, s1, 8'h01, s2});
    chk(wd[0] == cur_pc[15:8] && wd[1] == cur_pc[7:0], "R2", "pushed pc",
        {wd[0], wd[1]}, cur_pc);
    chk(wd[2] == ((cur_p & 8'hEF) | 8'h20), "R3", "pushed status",
        wd[2], (cur_p & 8'hEF) | 8'h20);
    chk(rn == 2 && ra[0] == base && ra[1] == base + 16'd1, req,
        "vector reads", {ra[0], ra[1]}, {base, base + 16'd1});
    chk(l_pc == {vbyte(base + 16'd1), vbyte(base)}, req, "new pc",
        l_pc, {vbyte(base + 16'd1), vbyte(base)});
    chk(l_p == ep, is_nmi ? "R4" : "R5", "new status", l_p, ep);
    chk(l_sp == s3 && l_spl && !l_jc, "R2", "new sp", l_sp, s3);
  endtask

  task automatic check_none(input string req, input string what);
    chk(busy_n == 0 && wn == 0 && load_n == 0, req, what,
        busy_n + wn + load_n, 0);
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R1: reset entry
    repeat (4) @(negedge clk);
    clear_log();
    @(negedge clk) rst = 1'b0;
    settle();
    chk(load_n == 1 && rn >= 2 && ra[(rn > 8 ? 8 : rn) - 2] == 16'hFFFC &&
        ra[(rn > 8 ? 8 : rn) - 1] == 16'hFFFD, "R1", "reset reads",
        load_n, 1);
    chk(l_pc == {vbyte(16'hFFFD), vbyte(16'hFFFC)}, "R1", "reset pc",
        l_pc, {vbyte(16'hFFFD), vbyte(16'hFFFC)});
    chk(l_p == 8'h04 && l_jc && !l_spl && wn == 0, "R1", "reset status",
        l_p, 8'h04);
    chk(!busy, "R1", "idle after reset", busy, 0);

    // R4 R2 R3: non-maskable entries over a sweep of pc/status/sp
    for (int k = 0; k < 6; k++) begin
      setup(16'h1234 + 16'(k) * 16'h3F01, 8'hFF ^ 8'(k * 37),
            8'hFD - 8'(k * 8'h55));
      clear_log();
      pulse_nmi();
      do_boundary();
      settle();
      check_entry(1'b1, "R4");
    end

    // R2: stack pointer wrap
    for (int k = 0; k < 3; k++) begin
      setup(16'hA5C3 ^ 16'(k), 8'h30 | 8'(k), 8'(k));
      clear_log();
      pulse_nmi();
      do_boundary();
      settle();
      check_entry(1'b1, "R2");
    end

    // R5: maskable entries, each source bit
    for (int k = 0; k < 4; k++) begin
      setup(16'h8000 + 16'(k * 77), 8'h00 | 8'(k * 8'h41), 8'hF0 - 8'(k));
      @(negedge clk) begin irq_src = 4'(1 << k); i_prev = 1'b0; end
      clear_log();
      do_boundary();
      @(negedge clk) irq_src = '0;
      settle();
      check_entry(1'b0, "R5");
    end

    // R6: masked level request ignored
    setup(16'h4444, 8'h04, 8'hE0);
    @(negedge clk) begin irq_src = 4'b1001; i_prev = 1'b1; end
    clear_log();
    do_boundary();
    settle();
    check_none("R6", "masked level irq");
    @(negedge clk) begin irq_src = '0; i_prev = 1'b0; end

    // R7: both at one boundary, then R8 level persists
    setup(16'h2468, 8'hC3, 8'hFF);
    @(negedge clk) irq_src = 4'b0010;
    clear_log();
    pulse_nmi();
    do_boundary();
    settle();
    check_entry(1'b1, "R7");
    clear_log();
    do_boundary();
    @(negedge clk) irq_src = '0;
    settle();
    check_entry(1'b0, "R8");

    // R6 R8: jammed refuses non-maskable, and the request is discarded
    @(negedge clk) jammed = 1'b1;
    clear_log();
    pulse_nmi();
    do_boundary();
    settle();
    check_none("R6", "jammed nmi");
    @(negedge clk) irq_src = 4'b0100;
    clear_log();
    do_boundary();
    settle();
    check_none("R6", "jammed irq");
    @(negedge clk) begin jammed = 1'b0; irq_src = '0; end
    clear_log();
    do_boundary();
    settle();
    check_none("R8", "nmi discarded after jammed boundary");

    // R8: masked one-shot dropped
    @(negedge clk) i_prev = 1'b1;
    clear_log();
    pulse_os();
    do_boundary();
    settle();
    check_none("R6", "masked one-shot");
    @(negedge clk) i_prev = 1'b0;
    clear_log();
    do_boundary();
    settle();
    check_none("R8", "one-shot discarded");

    // R6: unmasked one-shot taken
    setup(16'h0F0F, 8'h81, 8'h80);
    clear_log();
    pulse_os();
    do_boundary();
    settle();
    check_entry(1'b0, "R6");

    // R9: non-maskable held away from a boundary
    setup(16'h7777, 8'h01, 8'h40);
    clear_log();
    pulse_nmi();
    settle();
    check_none("R9", "no boundary, no entry");
    clear_log();
    do_boundary();
    settle();
    check_entry(1'b1, "R9");

    // R9: non-maskable strobe during a maskable entry is held
    setup(16'h5A5A, 8'h00, 8'h90);
    @(negedge clk) irq_src = 4'b0001;
    clear_log();
    do_boundary();
    @(negedge clk) irq_src = '0;
    pulse_nmi();
    settle();
    check_entry(1'b0, "R9");
    clear_log();
    do_boundary();
    settle();
    check_entry(1'b1, "R9");

    // R9: boundary held high through an entry gives one entry only
    setup(16'h1111, 8'h22, 8'h33);
    clear_log();
    pulse_nmi();
    @(negedge clk) insn_boundary = 1'b1;
    repeat (10) @(negedge clk);
    insn_boundary = 1'b0;
    settle();
    chk(busy_n == 7 && load_n == 1, "R9", "boundary held", busy_n, 7);

    // R10: vector data taken one cycle after the read strobe
    setup(16'h3C3C, 8'h10, 8'h20);
    clear_log();
    pulse_nmi();
    do_boundary();
    settle();
    chk(l_pc == {vbyte(16'hFFFB), vbyte(16'hFFFA)}, "R10", "read timing",
        l_pc, {vbyte(16'hFFFB), vbyte(16'hFFFA)});

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule